// File: doc/BRIEF.md
# Pulse-Frequency Modulated Pulse Generator

This block turns a 16-bit rate command into a train of short pulses of fixed, programmable width. A phase accumulator adds the rate command once per PFM clock-enable strobe. Each carry out of its top bit starts one output pulse. The pulse then stays high for a programmed number of PFM clock enables. Over any span of 65536 enables, the number of pulses equals the command value, so the pulse rate is the PFM clock rate times the command divided by 65536. At a 9.83 MHz PFM clock, a command of 11 gives about 1.65 kHz, and a width of 15 gives a pulse of about 1.5 µs.

The output pin is shared. A 2-bit format field selects what drives it. When the field's upper bit is set (values 2 and 3), the pin carries the generated pulse train. For values 0 and 1, the pin passes through an externally supplied PWM comparator signal. The busy flag reports the generator's own pulse in every format.

Inside, a two-state machine times the pulse. It has the states ST_IDLE and ST_ACTIVE and the following transitions:
- T_START goes from idle to active on a carry while the width is non-zero. It latches the width.
- T_COUNT stays active and steps the remaining count down on each enable.
- T_END goes from active to idle on the enable that uses up the count.
- T_RESET forces idle from either state.

Top module: `pfm_pulse_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator to zero and the remaining count, and forces `busy` low. With the format at 2 or 3, this drives `pulse_out` low. The reset can interrupt a pulse in progress.
- R2: The 16-bit accumulator advances only on clock edges where `pfm_ce` is high. At those edges it adds `freq_cmd` modulo 65536. On edges without `pfm_ce`, neither the accumulator nor the pulse state changes.
- R3: Starting from a cleared accumulator, 65536 consecutive enables with command C produce exactly C pulse starts. For C = 11, that is 11 pulses with width 15.
- R4: A command of zero never starts a pulse.
- R5: An enable edge whose addition carries out of bit 15, with `busy` low and `width_cnt` non-zero, raises `busy` after that edge. `busy` then stays high through exactly `width_cnt` enable edges and falls after the last of them.
- R6: A carry that occurs while `busy` is high is discarded. It neither restarts, stretches nor queues a pulse. This includes a carry on the enable that ends the pulse.
- R7: A `width_cnt` of zero suppresses pulses entirely. Carries seen at that time are discarded.
- R8: The width is captured when a pulse starts. Changing `width_cnt` during a pulse has no effect on that pulse's length.
- R9: When `fmt_sel` is 2 or 3, `pulse_out` equals `busy`. When `fmt_sel` is 0 or 1, `pulse_out` equals `pwm_in` in the same cycle, and the generator keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pfm_ce | input | 1 | PFM clock-enable strobe, one system clock wide |
| freq_cmd | input | ACC_BITS (16) | Rate command added per enable |
| width_cnt | input | CNT_BITS (8) | Pulse width in PFM enables |
| fmt_sel | input | 2 | Output format: 2/3 pulse train, 0/1 PWM pass-through |
| pwm_in | input | 1 | External PWM comparator output |
| pulse_out | output | 1 | Shared output pin |
| busy | output | 1 | High while a generated pulse is active |

## Verification
A corrupted accumulator shows up as a misplaced pulse start. That is visible on `busy` at the first carry it shifts, which can be thousands of enables later at small commands. The long 65536-enable run with a command of 11 therefore checks both the exact start of every pulse and the total pulse count.

A wrong remaining count or a missed T_END shows up within one pulse as a `busy` length other than the captured width. A lost or spurious retrigger appears at the next carry that arrives during a pulse.

Format-select faults appear in the same cycle on `pulse_out`, because the pass-through path has no register.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } pfm_state_t;

    localparam int FMT_BITS = 2;

    // Formats 2 and 3 select the generated pulse train.
    function automatic logic fmt_is_pulse(input logic [FMT_BITS-1:0] f);
        return f[FMT_BITS-1];
    endfunction

endpackage

// File: rtl/pfm_phase_acc.sv
module pfm_phase_acc #(
    parameter int ACC_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic [ACC_BITS-1:0] cmd,
    output logic                carry
);
    localparam int SUM_BITS = ACC_BITS + 1;

    logic [ACC_BITS-1:0] acc_q;
    logic [SUM_BITS-1:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, cmd};
        carry = ce & sum[SUM_BITS-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ce) begin
            acc_q <= sum[ACC_BITS-1:0];
        end
    end
endmodule

// File: rtl/pfm_width_fsm.sv
module pfm_width_fsm
    import pfm_pkg::*;
#(
    parameter int CNT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                trig,
    input  logic [CNT_BITS-1:0] width,
    output logic                busy
);
    localparam logic [CNT_BITS-1:0] ONE = CNT_BITS'(1);

    pfm_state_t          state_q, state_d;
    logic [CNT_BITS-1:0] rem_q, rem_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;                    // T_RESET
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig && (width != '0)) begin   // T_START
                    state_d = ST_ACTIVE;
                    rem_d   = width;
                end
            end
            ST_ACTIVE: begin
                busy = 1'b1;
                if (ce) begin
                    if (rem_q == ONE) begin        // T_END
                        state_d = ST_IDLE;
                        rem_d   = '0;
                    end else begin                 // T_COUNT
                        rem_d = rem_q - ONE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pfm_out_sel.sv
module pfm_out_sel
    import pfm_pkg::*;
(
    input  logic [FMT_BITS-1:0] fmt,
    input  logic                pulse_level,
    input  logic                pwm_level,
    output logic                pin
);
    always_comb begin
        pin = fmt_is_pulse(fmt) ? pulse_level : pwm_level;
    end
endmodule

// File: rtl/pfm_pulse_gen.sv
module pfm_pulse_gen
    import pfm_pkg::*;
#(
    parameter int ACC_BITS = 16,
    parameter int CNT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pfm_ce,
    input  logic [ACC_BITS-1:0] freq_cmd,
    input  logic [CNT_BITS-1:0] width_cnt,
    input  logic [1:0]          fmt_sel,
    input  logic                pwm_in,
    output logic                pulse_out,
    output logic                busy
);
    logic carry;

    pfm_phase_acc #(.ACC_BITS(ACC_BITS)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ce    (pfm_ce),
        .cmd   (freq_cmd),
        .carry (carry)
    );

    pfm_width_fsm #(.CNT_BITS(CNT_BITS)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .ce    (pfm_ce),
        .trig  (carry),
        .width (width_cnt),
        .busy  (busy)
    );

    pfm_out_sel u_sel (
        .fmt         (fmt_sel),
        .pulse_level (busy),
        .pwm_level   (pwm_in),
        .pin         (pulse_out)
    );
endmodule

// File: rtl/pfm_pulse_gen_chk.sv
module pfm_pulse_gen_chk #(
    parameter int ACC_BITS = 16,
    parameter int CNT_BITS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                pfm_ce,
    input logic [ACC_BITS-1:0] freq_cmd,
    input logic [CNT_BITS-1:0] width_cnt,
    input logic [1:0]          fmt_sel,
    input logic                pwm_in,
    input logic                pulse_out,
    input logic                busy
);
    logic [CNT_BITS:0]   run_q;
    logic [CNT_BITS-1:0] lat_q;
    logic [CNT_BITS:0]   run_nx;

    assign run_nx = run_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_q <= '0;
        end else if (pfm_ce) begin
            run_q <= run_nx;
        end
        if (rst) begin
            lat_q <= '0;
        end else if (!busy) begin
            lat_q <= width_cnt;
        end
    end

    AST_RST_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !busy); // R1
    AST_IDLE_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst) (!pfm_ce && !busy) |=> !busy); // R2
    AST_BUSY_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst) (!pfm_ce && busy) |=> busy); // R5
    AST_ZERO_CMD_QUIET: assert property (@(posedge clk) disable iff (rst) (freq_cmd == '0 && !busy) |=> !busy); // R4
    AST_ZERO_WIDTH_QUIET: assert property (@(posedge clk) disable iff (rst) (width_cnt == '0 && !busy) |=> !busy); // R7
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst) (busy && pfm_ce && run_nx == {1'b0, lat_q}) |=> !busy); // R5
    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy && pfm_ce && run_nx < {1'b0, lat_q}) |=> busy); // R8
    AST_PWM_PATH: assert property (@(posedge clk) disable iff (rst) !fmt_sel[1] |-> (pulse_out == pwm_in)); // R9
    AST_PFM_PATH: assert property (@(posedge clk) disable iff (rst) fmt_sel[1] |-> (pulse_out == busy)); // R9
endmodule

bind pfm_pulse_gen pfm_pulse_gen_chk #(.ACC_BITS(ACC_BITS), .CNT_BITS(CNT_BITS)) u_chk (.*);

// File: tb/pfm_pulse_gen_test.sv
`timescale 1ns/1ps
module pfm_pulse_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pfm_ce = 1'b0;
    logic [15:0] freq_cmd = '0;
    logic [7:0]  width_cnt = 8'd15;
    logic [1:0]  fmt_sel = 2'd3;
    logic        pwm_in = 1'b0;
    logic        pulse_out, busy;

    always #2.5 clk = ~clk;

    pfm_pulse_gen uut (
        .clk(clk), .rst(rst), .pfm_ce(pfm_ce), .freq_cmd(freq_cmd),
        .width_cnt(width_cnt), .fmt_sel(fmt_sel), .pwm_in(pwm_in),
        .pulse_out(pulse_out), .busy(busy)
    );

    int errors = 0;
    int checks = 0;
    int rises  = 0;

    // driver intent
    logic        d_rst = 1'b1, d_ce = 1'b0, d_pwm = 1'b0;
    logic [15:0] d_cmd = '0;
    logic [7:0]  d_wid = 8'd15;
    logic [1:0]  d_fmt = 2'd3;

    // requirement-level model state
    logic [15:0] m_acc = '0;
    logic        m_busy = 1'b0;
    int          m_rem = 0;

    logic  exp_p[$];
    logic  exp_b[$];
    string exp_t[$];

    task automatic tick(input string tag);
        logic [16:0] s;
        @(negedge clk);
        rst = d_rst; pfm_ce = d_ce; freq_cmd = d_cmd;
        width_cnt = d_wid; fmt_sel = d_fmt; pwm_in = d_pwm;
        if (d_rst) begin
            m_acc = '0; m_busy = 1'b0; m_rem = 0;
        end else if (d_ce) begin
            s = {1'b0, m_acc} + {1'b0, d_cmd};
            m_acc = s[15:0];
            if (m_busy) begin
                if (m_rem == 1) m_busy = 1'b0;
                else m_rem = m_rem - 1;
            end else if (s[16] && d_wid != 0) begin
                m_busy = 1'b1;
                m_rem = int'(d_wid);
            end
        end
        exp_p.push_back(d_fmt[1] ? m_busy : d_pwm);
        exp_b.push_back(m_busy);
        exp_t.push_back(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic check_eq(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // monitor
    logic  mon_p, mon_b, prev_b = 1'b0;
    string mon_t;
    always @(posedge clk) begin
        #1;
        if (exp_p.size() > 0) begin
            mon_p = exp_p.pop_front();
            mon_b = exp_b.pop_front();
            mon_t = exp_t.pop_front();
            checks++;
            if (pulse_out !== mon_p || busy !== mon_b) begin
                errors++;
                $display("FAIL %s: pulse_out=%0b busy=%0b expected pulse_out=%0b busy=%0b",
                         mon_t, pulse_out, busy, mon_p, mon_b);
            end
        end
        if (busy === 1'b1 && prev_b === 1'b0) rises++;
        prev_b = busy;
    end

    task automatic do_reset(input string tag);
        d_rst = 1'b1; d_ce = 1'b0;
        run(3, tag);
        d_rst = 1'b0;
    endtask

    initial begin
        int r0;
        // R1: reset state
        d_fmt = 2'd3;
        do_reset("R1");
        run(2, "R1");

        // R5: regular pulses, width 3
        d_cmd = 16'h4000; d_wid = 8'd3; d_ce = 1'b1;
        run(40, "R5");

        // R2: sparse enables
        do_reset("R1");
        d_cmd = 16'h8000; d_wid = 8'd2;
        for (int i = 0; i < 60; i++) begin
            d_ce = (i % 3 == 0);
            tick("R2");
        end

        // R6: carries during active pulse are dropped
        do_reset("R1");
        d_cmd = 16'hC000; d_wid = 8'd5; d_ce = 1'b1;
        r0 = rises;
        run(36, "R6");
        d_ce = 1'b0; run(2, "R6");
        check_eq("R6 pulse count", rises - r0, 6);

        // R1: reset in the middle of a pulse
        d_cmd = 16'h8000; d_wid = 8'd10; d_ce = 1'b1;
        run(4, "R1");
        do_reset("R1");
        run(1, "R1");

        // R7: zero width
        d_cmd = 16'h8000; d_wid = 8'd0; d_ce = 1'b1;
        r0 = rises;
        run(30, "R7");
        check_eq("R7 pulse count", rises - r0, 0);

        // R4: zero command
        d_cmd = 16'h0000; d_wid = 8'd4;
        r0 = rises;
        run(50, "R4");
        check_eq("R4 pulse count", rises - r0, 0);

        // R8: width change mid-pulse
        do_reset("R1");
        d_cmd = 16'h8000; d_wid = 8'd6; d_ce = 1'b1;
        run(3, "R8");
        d_wid = 8'd1;
        run(8, "R8");
        d_wid = 8'd9;
        run(12, "R8");

        // R9: format select
        d_cmd = 16'h5555; d_wid = 8'd2;
        for (int f = 0; f < 4; f++) begin
            d_fmt = 2'(f);
            for (int i = 0; i < 16; i++) begin
                d_pwm = (i % 3 == 1);
                tick("R9");
            end
        end
        d_fmt = 2'd3; d_pwm = 1'b0;

        // R3: full accumulator cycle with command 11
        do_reset("R1");
        d_cmd = 16'd11; d_wid = 8'd15; d_ce = 1'b1;
        r0 = rises;
        run(65536, "R3");
        d_ce = 1'b0;
        run(3, "R3");
        check_eq("R3 pulses per 65536 enables", rises - r0, 11);

        repeat (3) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule